// File: doc/BRIEF.md
# Strip-Mining Vector Length Controller

This block turns a loop of arbitrary trip count into a series of strips, each no longer than the hardware vector length. A start pulse carries a signed element count and a base element index. For every strip the controller presents a length and a starting element index to a downstream vector unit over a valid/ready pair. After the strip is accepted, the controller waits for a one-cycle strip-done pulse before it presents the next strip.

The first strip absorbs the remainder of the count modulo the maximum length. Every later strip therefore runs at full length. When no elements remain, the controller raises a one-cycle finish pulse and returns to idle. Arithmetic, address generation and memory traffic belong to the downstream unit.

Top module: `strip_sequencer`

## Requirements
- R1: After reset, `stripValid` and `finished` are both low.
- R2: A start with a count of zero or less issues no strip. `finished` goes high for exactly the cycle after the start cycle.
- R3: The first strip appears the cycle after an accepted start. Its length is the count modulo MAX_VL (64), or 64 when that remainder is 0. Its index is the base index.
- R4: Every strip after the first has length MAX_VL (64).
- R5: Each following strip's index is the previous index plus the previous length. Strips continue while the remaining count (count minus all lengths issued) is positive, so a count of N gives ceil(N/64) strips.
- R6: While `stripValid` is high and `stripReady` is low, `stripValid` stays high and `stripLen` and `stripIndex` stay unchanged.
- R7: After a strip is accepted, `stripValid` stays low until `stripDone` is seen. The next strip appears the cycle after `stripDone`.
- R8: `finished` is high for exactly one cycle, the cycle after the `stripDone` of the final strip, and `stripValid` is low in that cycle.
- R9: A start pulse while a job is in progress is ignored. The running job's strips are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| totalCount | input | 32 | Signed element count, sampled at start |
| baseIndex | input | 32 | First element index, sampled at start |
| stripValid | output | 1 | A strip is offered downstream |
| stripReady | input | 1 | Downstream accepts the offered strip |
| stripLen | output | 7 | Length of the offered strip (1..64) |
| stripIndex | output | 32 | Starting element index of the offered strip |
| stripDone | input | 1 | Downstream finished the accepted strip |
| finished | output | 1 | One-cycle pulse when the job completes |

## Verification
The bench sweeps the count across negative values, zero, 1 to 63, and the exact multiples of 64 with their neighbours. The multiples matter because a design that kept the raw remainder would issue an empty strip there or stop one strip early. A wrong index step or a stray partial strip after the first shows up as a mismatched length or index on a later strip. Random ready stalls expose a strip that changes or drops while it is held. Start pulses injected mid-job and done pulses held back catch a controller that restarts, or that runs ahead of the downstream unit. The finish pulse is checked for its exact cycle and width, so a late, early or doubled pulse is caught.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic loadJob;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/strip_control.sv
module strip_control
  import strip_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         countPositive,
  input  logic         lastStrip,
  input  logic         stripReady,
  input  logic         stripDone,
  output ctrlStrobes_t strobes,
  output logic         stripValid,
  output logic         finished
);
  seqState_t stateQ, stateD;
  logic      finishD, finishQ;

  always_comb begin
    stateD          = stateQ;
    strobes.loadJob = 1'b0;
    strobes.advance = 1'b0;
    finishD         = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          if (countPositive) begin
            strobes.loadJob = 1'b1;
            stateD          = ST_ISSUE;
          end else begin
            finishD = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (stripReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (stripDone) begin
          strobes.advance = 1'b1;
          if (lastStrip) begin
            finishD = 1'b1;
            stateD  = ST_IDLE;
          end else begin
            stateD = ST_ISSUE;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      finishQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      finishQ <= finishD;
    end
  end

  assign stripValid = (stateQ == ST_ISSUE);
  assign finished   = finishQ;
endmodule

// File: rtl/strip_datapath.sv
module strip_datapath
  import strip_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 32,
  localparam int VL_W  = $clog2(MAX_VL) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrlStrobes_t            strobes,
  input  logic signed [CNT_W-1:0] totalCount,
  input  logic [IDX_W-1:0]        baseIndex,
  output logic                    countPositive,
  output logic                    lastStrip,
  output logic [VL_W-1:0]         stripLen,
  output logic [IDX_W-1:0]        stripIndex
);
  logic signed [CNT_W-1:0] remainQ;
  logic [IDX_W-1:0]        indexQ;
  logic [VL_W-1:0]         lenQ;
  logic [CNT_W-1:0]        modFull;
  logic [VL_W-1:0]         firstLen;
  logic signed [CNT_W-1:0] lenWide;

  assign countPositive = (totalCount > 0);
  assign modFull  = $unsigned(totalCount) % CNT_W'(MAX_VL);
  assign firstLen = (modFull == '0) ? VL_W'(MAX_VL) : VL_W'(modFull);
  assign lenWide  = $signed({{(CNT_W-VL_W){1'b0}}, lenQ});
  assign lastStrip = (remainQ <= lenWide);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remainQ <= '0;
      indexQ  <= '0;
      lenQ    <= '0;
    end else if (strobes.loadJob) begin
      remainQ <= totalCount;
      indexQ  <= baseIndex;
      lenQ    <= firstLen;
    end else if (strobes.advance) begin
      remainQ <= remainQ - lenWide;
      indexQ  <= indexQ + IDX_W'(lenQ);
      lenQ    <= VL_W'(MAX_VL);
    end
  end

  assign stripLen   = lenQ;
  assign stripIndex = indexQ;
endmodule

// File: rtl/strip_sequencer.sv
module strip_sequencer
  import strip_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int CNT_W  = 32,
  parameter int IDX_W  = 32,
  localparam int VL_W  = $clog2(MAX_VL) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [CNT_W-1:0] totalCount,
  input  logic [IDX_W-1:0]        baseIndex,
  output logic                    stripValid,
  input  logic                    stripReady,
  output logic [VL_W-1:0]         stripLen,
  output logic [IDX_W-1:0]        stripIndex,
  input  logic                    stripDone,
  output logic                    finished
);
  ctrlStrobes_t strobes;
  logic         countPositive;
  logic         lastStrip;

  strip_control i_control (
    .clk(clk), .rst_n(rst_n), .start(start),
    .countPositive(countPositive), .lastStrip(lastStrip),
    .stripReady(stripReady), .stripDone(stripDone),
    .strobes(strobes), .stripValid(stripValid), .finished(finished)
  );

  strip_datapath #(.MAX_VL(MAX_VL), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_datapath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .totalCount(totalCount), .baseIndex(baseIndex),
    .countPositive(countPositive), .lastStrip(lastStrip),
    .stripLen(stripLen), .stripIndex(stripIndex)
  );
endmodule

// File: rtl/strip_sequencer_chk.sv
module strip_sequencer_chk #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = 32,
  localparam int VL_W  = $clog2(MAX_VL) + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            stripValid,
  input logic            stripReady,
  input logic [VL_W-1:0] stripLen,
  input logic [IDX_W-1:0] stripIndex,
  input logic            stripDone,
  input logic            finished
);
  // R6
  held_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stripValid && !stripReady |=> stripValid && $stable(stripLen) && $stable(stripIndex));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stripValid |-> (stripLen != '0) && (stripLen <= VL_W'(MAX_VL)));

  // R4
  full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stripValid) && $past(stripDone) && !$past(start) |-> stripLen == VL_W'(MAX_VL));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !finished);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !stripValid);

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stripValid && stripReady |=> !stripValid);
endmodule

bind strip_sequencer strip_sequencer_chk #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stripValid(stripValid),
  .stripReady(stripReady), .stripLen(stripLen), .stripIndex(stripIndex),
  .stripDone(stripDone), .finished(finished)
);

// File: tb/test_strip_sequencer.sv
module test_strip_sequencer;
  localparam int MAX_VL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic signed [31:0] totalCount = '0;
  logic [31:0] baseIndex = '0;
  logic        stripValid;
  logic        stripReady = 1'b0;
  logic [6:0]  stripLen;
  logic [31:0] stripIndex;
  logic        stripDone = 1'b0;
  logic        finished;

  int checks = 0;
  int errors = 0;
  int seed = 7;

  always #2.5 clk = ~clk;

  strip_sequencer i_strip_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .totalCount(totalCount),
    .baseIndex(baseIndex), .stripValid(stripValid), .stripReady(stripReady),
    .stripLen(stripLen), .stripIndex(stripIndex), .stripDone(stripDone),
    .finished(finished)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runJob(input int count, input int base, input bit stall, input bit poke);
    int remain = count;
    int idx = base;
    int len;
    int strips = 0;
    bit last;
    len = (count % MAX_VL == 0) ? MAX_VL : count % MAX_VL;
    totalCount = count;
    baseIndex  = base;
    start = 1'b1;
    tick();
    start = 1'b0;
    totalCount = 32'sd5;
    baseIndex  = 32'd999;
    if (count <= 0) begin
      check("R2 finished", finished, 1);
      check("R2 no strip", stripValid, 0);
      tick();
      check("R2 finish width", finished, 0);
      check("R2 still no strip", stripValid, 0);
      return;
    end
    forever begin
      check(strips == 0 ? "R3 valid" : "R7 next strip", stripValid, 1);
      check(strips == 0 ? "R3 len" : "R4 len", stripLen, len);
      check(strips == 0 ? "R3 index" : "R5 index", stripIndex, idx);
      if (stall) begin
        int d = $urandom(seed) % 4;
        seed++;
        for (int k = 0; k < d; k++) begin
          tick();
          check("R6 held valid", stripValid, 1);
          check("R6 held len", stripLen, len);
          check("R6 held index", stripIndex, idx);
        end
      end
      stripReady = 1'b1;
      tick();
      stripReady = 1'b0;
      check("R7 drop after accept", stripValid, 0);
      if (poke) start = 1'b1;
      tick();
      start = 1'b0;
      check(poke ? "R9 start ignored" : "R7 wait for done", stripValid, 0);
      check("R9 no finish", finished, 0);
      tick();
      check("R7 wait for done", stripValid, 0);
      strips++;
      remain -= len;
      idx += len;
      len = MAX_VL;
      last = (remain <= 0);
      stripDone = 1'b1;
      tick();
      stripDone = 1'b0;
      if (last) begin
        check("R8 finished", finished, 1);
        check("R8 no strip at finish", stripValid, 0);
        check("R5 strip count", strips, (count + MAX_VL - 1) / MAX_VL);
        tick();
        check("R8 finish width", finished, 0);
        check("R8 idle", stripValid, 0);
        return;
      end
      check("R5 no early finish", finished, 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    check("R1 valid in reset", stripValid, 0);
    check("R1 finished in reset", finished, 0);
    rst_n = 1'b1;
    tick();
    check("R1 valid after reset", stripValid, 0);
    check("R1 finished after reset", finished, 0);
    runJob(-2147483647 - 1, 0, 0, 0);
    for (int c = -3; c <= 200; c++) runJob(c, c * 3 + 17, c[0], c[1]);
    runJob(255, 32'h7fff_ff00, 1, 1);
    runJob(256, 1000, 1, 0);
    runJob(257, 0, 0, 1);
    runJob(640, 40, 1, 1);
    // Back-to-back: start in the very cycle after finish
    runJob(64, 5, 0, 0);
    runJob(0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule